// File: doc/BRIEF.md
# Byte-serial CRC-32 engine (generator 0x20044009)

This block keeps a running 32-bit cyclic redundancy check over a stream of bytes. Each byte is folded in most significant bit first against the generator x^32 + x^29 + x^18 + x^14 + x^3 + 1 (0x20044009). There is no reflection of input or output bits and no final inversion, so the register itself is the checksum.

A caller starts a computation by pulsing `load` with a seed, normally 0xFFFFFFFF. It then offers bytes on a valid/ready input, one per clock. The current value is visible on `crc_out` at all times. A multi-part message can be resumed by loading a previously read value as the seed.

Top module: `crc_byte_engine`

## Requirements
- R1: After reset `crc_out` is 0xFFFFFFFF.
- R2: `in_ready` is 1 in every cycle; a byte is accepted in every cycle where `in_valid` is 1.
- R3: For an accepted byte d with `load` low, the next value is (C << 8) XOR T[(C[31:24] XOR d)]. T[i] is built by placing i in bits 31:24 and then doing eight steps, each a shift left by one that is XORed with 0x20044009 when bit 31 was set before the shift.
- R4: With seed 0xFFFFFFFF, the bytes 0x01, 0x02, 0x03, 0x04 give 0xF33CB7D3.
- R5: `load` high with `in_valid` low writes `seed` into the register on the next edge. A message of zero length therefore returns the seed unchanged.
- R6: `load` and `in_valid` high in the same cycle give the R3 update applied to `seed` rather than to the old register.
- R7: With `load` and `in_valid` both low, `crc_out` holds its value.
- R8: No final XOR or bit reversal is applied. Over a message of any length, `crc_out` equals the R3 update chained over every accepted byte, even when idle cycles fall between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Write seed into the register |
| seed | input | 32 | Starting value for a computation |
| in_valid | input | 1 | Byte present on in_data |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Always 1 |
| crc_out | output | 32 | Current CRC register |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- The known four-byte vector catches a wrong polynomial, reflected shifting or an added final XOR, because each gives a value other than 0xF33CB7D3.
- A load in the same cycle as a byte catches a design that ignores the byte, or that folds the byte into the old register instead of the seed.
- A zero-length message and idle gaps inside a message catch a register that drifts when nothing is accepted.
- Random messages with random seeds, compared against a table-driven model, catch wrong bit order inside the eight-step update.

// File: rtl/crc_byte_engine.sv
module crc_byte_engine #(
  parameter int          CRC_W   = 32,
  parameter int          BYTE_W  = 8,
  parameter logic [31:0] POLY    = 32'h2004_4009,
  parameter logic [31:0] RST_VAL = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CRC_W-1:0]  seed,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic [CRC_W-1:0]  crc_out
);
  localparam int TOP = CRC_W - BYTE_W;

  function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] c,
                                            input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c ^ {d, {TOP{1'b0}}};
    for (int k = 0; k < BYTE_W; k++)
      r = r[CRC_W-1] ? ((r << 1) ^ POLY[CRC_W-1:0]) : (r << 1);
    return r;
  endfunction

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] base;

  assign in_ready = 1'b1;
  assign base     = load ? seed : crc_q;
  assign crc_out  = crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        crc_q <= RST_VAL[CRC_W-1:0];
    else if (in_valid) crc_q <= fold(base, in_data);
    else if (load)     crc_q <= seed;
  end
endmodule

// File: rtl/crc_byte_engine_chk.sv
module crc_byte_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load,
  input logic [31:0] seed,
  input logic        in_valid,
  input logic [7:0]  in_data,
  input logic        in_ready,
  input logic [31:0] crc_out
);
  assert_ready_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  assert_load_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !in_valid) |=> crc_out == $past(seed));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !in_valid) |=> $stable(crc_out));

  assert_zero_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && in_valid && in_data == crc_out[31:24]) |=> crc_out == {$past(crc_out[23:0]), 8'h00});

  assert_load_zero_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_valid && in_data == seed[31:24]) |=> crc_out == {$past(seed[23:0]), 8'h00});
endmodule

bind crc_byte_engine crc_byte_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .seed(seed), .in_valid(in_valid),
  .in_data(in_data), .in_ready(in_ready), .crc_out(crc_out)
);

// File: tb/sim_crc_byte_engine.sv
module sim_crc_byte_engine;
  logic clk = 0, rst_n = 0, load = 0, in_valid = 0;
  logic [31:0] seed = 0;
  logic [7:0]  in_data = 0;
  logic        in_ready;
  logic [31:0] crc_out;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] tbl [256];

  always #4 clk = ~clk;

  crc_byte_engine u0 (.clk(clk), .rst_n(rst_n), .load(load), .seed(seed),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .crc_out(crc_out));

  function automatic logic [31:0] mk_entry(input int i);
    logic [31:0] c = i << 24;
    for (int j = 0; j < 8; j++) c = c[31] ? ((c << 1) ^ 32'h20044009) : (c << 1);
    return c;
  endfunction

  function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] d);
    return (c << 8) ^ tbl[c[31:24] ^ d];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [7:0] d, input bit l, input logic [31:0] s);
    in_valid = v; in_data = d; load = l; seed = s;
    @(negedge clk);
    in_valid = 0; load = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] m;
    void'($urandom(32'h1234));
    for (int i = 0; i < 256; i++) tbl[i] = mk_entry(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset", crc_out, 32'hFFFFFFFF);
    check("R2 ready", {31'd0, in_ready}, 32'd1);

    cyc(0, 0, 1, 32'hFFFFFFFF);
    cyc(1, 8'h01, 0, 0); cyc(1, 8'h02, 0, 0); cyc(1, 8'h03, 0, 0); cyc(1, 8'h04, 0, 0);
    check("R4 vector", crc_out, 32'hF33CB7D3);

    cyc(0, 0, 1, 32'h12345678);
    check("R5 zero-length", crc_out, 32'h12345678);
    repeat (3) cyc(0, 8'hAA, 0, 32'hDEADBEEF);
    check("R7 hold", crc_out, 32'h12345678);

    cyc(1, 8'h5A, 1, 32'hCAFEF00D);
    check("R6 load+byte", crc_out, ref_step(32'hCAFEF00D, 8'h5A));

    m = crc_out;
    cyc(1, 8'h00, 0, 0);
    check("R3 zero byte", crc_out, ref_step(m, 8'h00));
    m = crc_out;
    cyc(1, 8'hFF, 0, 0);
    check("R3 ff byte", crc_out, ref_step(m, 8'hFF));

    cyc(1, 8'h01, 1, 32'hFFFFFFFF);
    cyc(0, 0, 0, 0); cyc(1, 8'h02, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    cyc(1, 8'h03, 0, 0); cyc(1, 8'h04, 0, 0);
    check("R8 gaps vector", crc_out, 32'hF33CB7D3);

    for (int t = 0; t < 40; t++) begin
      logic [31:0] s = $urandom;
      int n = $urandom_range(0, 20);
      m = s;
      cyc(0, 0, 1, s);
      for (int b = 0; b < n; b++) begin
        logic [7:0] d = 8'($urandom);
        if ($urandom_range(0, 3) == 0) cyc(0, 0, 0, 0);
        cyc(1, d, 0, 0);
        m = ref_step(m, d);
      end
      check("R8 random message", crc_out, m);
      check("R2 ready random", {31'd0, in_ready}, 32'd1);
    end

    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    check("R1 re-reset", crc_out, 32'hFFFFFFFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule